// File: doc/BRIEF.md
# Link-Layer Security Admission Checker

This block decides whether an incoming secured frame may go on to authenticated decryption. For each request it takes the frame's 3-bit protection level, the sender's neighbor index and the frame counter. It then checks three things in a fixed order: whether local policy allows that level, whether the encryption-only level is barred, and whether the counter is fresh. It returns a registered verdict one clock later, together with a reason code, the decoded payload-encryption flag and the integrity-tag length.

Two counter sources are supported. In legacy mode the counter is the 32-bit value carried in the frame's security header. The block keeps one last-accepted value per neighbor and rejects any frame whose counter does not strictly exceed it. In slotted channel-hopping mode the counter is the network-wide 40-bit slot number, so no per-neighbor table is consulted. The selected counter is reported with each verdict so that the nonce builder downstream can use it.

The table is not written when a frame is admitted. It is written only when the downstream cryptographic engine reports that the frame passed integrity checking. That report arrives on a separate commit strobe carrying the neighbor index and counter, so a forged frame can never advance a neighbor's counter.

Top module: `lsec_gate`

## Requirements
- R1: Every verdict reports the level decode: the encrypt flag is set for levels 4 to 7, and the tag length in bytes follows level bits [1:0] as 0→0, 1→4, 2→8, 3→16. The decode is reported whether the frame is accepted or rejected.
- R2: If bit L of `policy_mask` is clear for the frame's level L, the verdict is reject with reason 1. This test takes priority over every other test.
- R3: When `strict_rev` is high, level 4 (encryption with no tag) is rejected with reason 2 if policy allows it. When `strict_rev` is low, level 4 is accepted like any other level. Reason 2 takes priority over reason 3.
- R4: In legacy mode, a secured frame from a neighbor with a recorded counter is rejected with reason 3 when its counter is less than or equal to the recorded value, and accepted when it is greater.
- R5: A neighbor entry with no commit since reset accepts any counter, including 0.
- R6: A check never changes the table; only a commit strobe in legacy mode records `commit_ctr` for `commit_nbr`.
- R7: In slotted mode no frame is rejected with reason 3. `res_ctr` carries the slot number in slotted mode and the zero-extended header counter in legacy mode.
- R8: Level 0 frames (unsecured) skip the replay test.
- R9: A request accepted on one rising edge gives `res_valid` high for exactly one cycle after that edge. `res_accept` is high exactly when the reason is 0. After reset all outputs are 0.
- R10: A commit strobe issued while `mode_tsch` is high leaves the table unchanged.
- R11: A check and a commit to the same neighbor in the same cycle compare against the value recorded before that commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_tsch | input | 1 | 1: slotted mode, counter is the slot number; 0: legacy header counter |
| strict_rev | input | 1 | 1: bar the encryption-only level |
| policy_mask | input | 8 | Bit L allows protection level L |
| chk_req | input | 1 | Single-cycle check request |
| chk_level | input | 3 | Frame protection level |
| chk_nbr | input | NBR_W | Sender neighbor index |
| chk_hdr_ctr | input | HDR_CTR_W | Counter from the security header |
| chk_asn | input | ASN_W | Current slot number |
| commit_req | input | 1 | Integrity pass strobe from the crypto engine |
| commit_nbr | input | NBR_W | Neighbor index of the passed frame |
| commit_ctr | input | HDR_CTR_W | Counter of the passed frame |
| res_valid | output | 1 | Verdict strobe |
| res_accept | output | 1 | Frame may proceed to cryptographic checking |
| res_reason | output | 2 | 0 accept, 1 policy, 2 encryption-only barred, 3 replay |
| res_encrypt | output | 1 | Payload is encrypted |
| res_mic_len | output | 5 | Tag length in bytes |
| res_ctr | output | ASN_W | Counter selected for the nonce |

## Verification
On every cycle the assertions check four things: the verdict strobe follows a request, policy failures and barred encryption-only frames produce their reason codes, slotted-mode frames never receive a replay verdict, and commits mark the entry as recorded while the record flags stay unchanged when no commit arrives. The stateful replay behaviour can only be shown by the bench's scenarios: the strict-greater comparison at the stored value, fresh entries, the absence of writes on check, commits ignored in slotted mode and the same-cycle commit ordering. The bench also shows the level decode and the counter selection across all levels.

// File: rtl/lsec_pkg.sv
package lsec_pkg;

  localparam int LVL_W = 3;
  localparam int LVL_N = 1 << LVL_W;
  localparam int MIC_W = 5;

  typedef enum logic [1:0] {
    RSN_OK      = 2'd0,
    RSN_POLICY  = 2'd1,
    RSN_ENCONLY = 2'd2,
    RSN_REPLAY  = 2'd3
  } rsn_e;

  // tag length in bytes from the low two level bits
  function automatic logic [MIC_W-1:0] mic_bytes(input logic [1:0] sel);
    logic [MIC_W-1:0] r;
    case (sel)
      2'd1:    r = 5'd4;
      2'd2:    r = 5'd8;
      2'd3:    r = 5'd16;
      default: r = 5'd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lsec_level_decode.sv
module lsec_level_decode
  import lsec_pkg::*;
(
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_N-1:0] policy_mask,
  input  logic             strict_rev,
  output logic             encrypt,
  output logic [MIC_W-1:0] mic_len,
  output logic             secured,
  output logic             policy_ok,
  output logic             enc_only_bad
);

  localparam logic [LVL_W-1:0] LVL_ENC_ONLY = LVL_W'(4);

  always_comb begin
    encrypt      = level[LVL_W-1];
    mic_len      = mic_bytes(level[1:0]);
    secured      = (level != '0);
    policy_ok    = policy_mask[level];
    enc_only_bad = strict_rev && (level == LVL_ENC_ONLY);
  end

endmodule

// File: rtl/lsec_replay_table.sv
module lsec_replay_table #(
  parameter int NBR_W = 3,
  parameter int CTR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBR_W-1:0] rd_nbr,
  input  logic [CTR_W-1:0] rd_ctr,
  output logic             rd_fresh,
  input  logic             wr_en,
  input  logic [NBR_W-1:0] wr_nbr,
  input  logic [CTR_W-1:0] wr_ctr
);

  localparam int NBR_N = 1 << NBR_W;

  logic [NBR_N-1:0] vld_q;
  logic [NBR_N-1:0] vld_d;
  logic [CTR_W-1:0] cnt_q [NBR_N];
  logic [CTR_W-1:0] cnt_d [NBR_N];
  logic [NBR_N-1:0] ent_we;

  // read side sees only registered state: a same-cycle write is not visible
  always_comb begin
    rd_fresh = !vld_q[rd_nbr] || (rd_ctr > cnt_q[rd_nbr]);
  end

  for (genvar gi = 0; gi < NBR_N; gi++) begin : g_ent
    always_comb begin
      ent_we[gi] = wr_en && (wr_nbr == NBR_W'(gi));
      vld_d[gi]  = ent_we[gi] ? 1'b1 : vld_q[gi];
      cnt_d[gi]  = ent_we[gi] ? wr_ctr : cnt_q[gi];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[gi] <= 1'b0;
        cnt_q[gi] <= '0;
      end else if (ent_we[gi]) begin
        vld_q[gi] <= vld_d[gi];
        cnt_q[gi] <= cnt_d[gi];
      end
    end
  end

  // R6: a commit marks its entry as recorded
  a_r6_commit_marks: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(wr_nbr)]);

  // R6 / R10: without a write strobe no record flag changes
  a_r6_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(vld_q));

endmodule

// File: rtl/lsec_gate.sv
module lsec_gate
  import lsec_pkg::*;
#(
  parameter int NBR_W     = 3,
  parameter int HDR_CTR_W = 32,
  parameter int ASN_W     = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_tsch,
  input  logic                 strict_rev,
  input  logic [7:0]           policy_mask,
  input  logic                 chk_req,
  input  logic [2:0]           chk_level,
  input  logic [NBR_W-1:0]     chk_nbr,
  input  logic [HDR_CTR_W-1:0] chk_hdr_ctr,
  input  logic [ASN_W-1:0]     chk_asn,
  input  logic                 commit_req,
  input  logic [NBR_W-1:0]     commit_nbr,
  input  logic [HDR_CTR_W-1:0] commit_ctr,
  output logic                 res_valid,
  output logic                 res_accept,
  output logic [1:0]           res_reason,
  output logic                 res_encrypt,
  output logic [4:0]           res_mic_len,
  output logic [ASN_W-1:0]     res_ctr
);

  localparam int PAD_W = ASN_W - HDR_CTR_W;

  logic             dec_enc;
  logic [MIC_W-1:0] dec_mic;
  logic             dec_secured;
  logic             dec_policy_ok;
  logic             dec_enc_only_bad;
  logic             tab_fresh;
  logic             tab_we;

  rsn_e             rsn_d, rsn_q;
  logic             acc_d, acc_q;
  logic [ASN_W-1:0] ctr_d, ctr_q;
  logic             enc_q;
  logic [MIC_W-1:0] mic_q;
  logic             vld_q;

  lsec_level_decode u_dec (
    .level        (chk_level),
    .policy_mask  (policy_mask),
    .strict_rev   (strict_rev),
    .encrypt      (dec_enc),
    .mic_len      (dec_mic),
    .secured      (dec_secured),
    .policy_ok    (dec_policy_ok),
    .enc_only_bad (dec_enc_only_bad)
  );

  // table updates only on a legacy-mode integrity pass
  always_comb tab_we = commit_req && !mode_tsch;

  lsec_replay_table #(
    .NBR_W (NBR_W),
    .CTR_W (HDR_CTR_W)
  ) u_tab (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_nbr   (chk_nbr),
    .rd_ctr   (chk_hdr_ctr),
    .rd_fresh (tab_fresh),
    .wr_en    (tab_we),
    .wr_nbr   (commit_nbr),
    .wr_ctr   (commit_ctr)
  );

  // verdict with fixed priority: policy, encryption-only, replay
  always_comb begin
    if (!dec_policy_ok)                             rsn_d = RSN_POLICY;
    else if (dec_enc_only_bad)                      rsn_d = RSN_ENCONLY;
    else if (!mode_tsch && dec_secured && !tab_fresh) rsn_d = RSN_REPLAY;
    else                                            rsn_d = RSN_OK;
    acc_d = (rsn_d == RSN_OK);
    ctr_d = mode_tsch ? chk_asn : {{PAD_W{1'b0}}, chk_hdr_ctr};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= chk_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsn_q <= RSN_OK;
      acc_q <= 1'b0;
      ctr_q <= '0;
      enc_q <= 1'b0;
      mic_q <= '0;
    end else if (chk_req) begin
      rsn_q <= rsn_d;
      acc_q <= acc_d;
      ctr_q <= ctr_d;
      enc_q <= dec_enc;
      mic_q <= dec_mic;
    end
  end

  always_comb begin
    res_valid   = vld_q;
    res_accept  = acc_q;
    res_reason  = rsn_q;
    res_encrypt = enc_q;
    res_mic_len = mic_q;
    res_ctr     = ctr_q;
  end

  // R9: a verdict strobe only follows a request
  a_r9_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(chk_req));

  // R2: a level outside the policy mask is always a policy reject
  a_r2_policy_first: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_req && !policy_mask[chk_level]) |=> (res_valid && res_reason == 2'd1 && !res_accept));

  // R3: barred encryption-only level gives reason 2 when policy allows it
  a_r3_enc_only_barred: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_req && strict_rev && chk_level == 3'd4 && policy_mask[4]) |=> (res_reason == 2'd2));

  // R1: an encryption-only reject carries encrypt set and no tag
  a_r1_enc_only_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_reason == 2'd2) |-> (res_encrypt && res_mic_len == 5'd0));

  // R7: slotted mode never yields a replay verdict
  a_r7_tsch_no_replay: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_req && mode_tsch) |=> (res_reason != 2'd3));

endmodule

// File: tb/lsec_gate_test.sv
module lsec_gate_test;

  localparam int NBR_W = 3;

  logic        clk;
  logic        rst_n;
  logic        mode_tsch;
  logic        strict_rev;
  logic [7:0]  policy_mask;
  logic        chk_req;
  logic [2:0]  chk_level;
  logic [2:0]  chk_nbr;
  logic [31:0] chk_hdr_ctr;
  logic [39:0] chk_asn;
  logic        commit_req;
  logic [2:0]  commit_nbr;
  logic [31:0] commit_ctr;
  logic        res_valid;
  logic        res_accept;
  logic [1:0]  res_reason;
  logic        res_encrypt;
  logic [4:0]  res_mic_len;
  logic [39:0] res_ctr;

  int total;
  int bad;
  bit done;

  lsec_gate #(.NBR_W(NBR_W), .HDR_CTR_W(32), .ASN_W(40)) uut (
    .clk(clk), .rst_n(rst_n), .mode_tsch(mode_tsch), .strict_rev(strict_rev),
    .policy_mask(policy_mask), .chk_req(chk_req), .chk_level(chk_level),
    .chk_nbr(chk_nbr), .chk_hdr_ctr(chk_hdr_ctr), .chk_asn(chk_asn),
    .commit_req(commit_req), .commit_nbr(commit_nbr), .commit_ctr(commit_ctr),
    .res_valid(res_valid), .res_accept(res_accept), .res_reason(res_reason),
    .res_encrypt(res_encrypt), .res_mic_len(res_mic_len), .res_ctr(res_ctr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [4:0] exp_mic(input logic [2:0] l);
    case (l[1:0])
      2'd1: return 5'd4;
      2'd2: return 5'd8;
      2'd3: return 5'd16;
      default: return 5'd0;
    endcase
  endfunction

  task automatic check_line(input string req, input bit ok, input string act, input string exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  // issue one check and compare the whole verdict one cycle later
  task automatic run_check(input string req, input logic [2:0] lvl, input logic [2:0] nbr,
                           input logic [31:0] hctr, input logic [39:0] asn,
                           input bit tsch, input logic [1:0] rsn);
    logic [39:0] ectr;
    bit ok;
    @(negedge clk);
    chk_req = 1'b1; chk_level = lvl; chk_nbr = nbr; chk_hdr_ctr = hctr;
    chk_asn = asn; mode_tsch = tsch;
    @(negedge clk);
    chk_req = 1'b0; mode_tsch = 1'b0;
    ectr = tsch ? asn : {8'h0, hctr};
    ok = res_valid && (res_accept == (rsn == 2'd0)) && (res_reason == rsn) &&
         (res_encrypt == lvl[2]) && (res_mic_len == exp_mic(lvl)) && (res_ctr == ectr);
    check_line(req, ok,
      $sformatf("v=%0b a=%0b r=%0d e=%0b m=%0d c=%0h", res_valid, res_accept, res_reason,
                res_encrypt, res_mic_len, res_ctr),
      $sformatf("v=1 a=%0b r=%0d e=%0b m=%0d c=%0h", rsn == 2'd0, rsn, lvl[2],
                exp_mic(lvl), ectr));
  endtask

  task automatic commit(input logic [2:0] nbr, input logic [31:0] ctr, input bit tsch);
    @(negedge clk);
    commit_req = 1'b1; commit_nbr = nbr; commit_ctr = ctr; mode_tsch = tsch;
    @(negedge clk);
    commit_req = 1'b0; mode_tsch = 1'b0;
  endtask

  task automatic t_reset;
    check_line("R9 reset", !res_valid && !res_accept && res_reason == 2'd0 &&
               !res_encrypt && res_mic_len == 5'd0 && res_ctr == 40'd0,
               $sformatf("v=%0b a=%0b r=%0d c=%0h", res_valid, res_accept, res_reason, res_ctr),
               "all zero");
  endtask

  task automatic t_decode;
    for (int l = 0; l < 8; l++)
      run_check("R1 decode", 3'(l), 3'd7, 32'(l + 1), 40'h0, 1'b0, 2'd0);
  endtask

  task automatic t_policy;
    int lv[4] = '{0, 3, 4, 6};
    foreach (lv[i]) begin
      policy_mask = 8'hFF & ~(8'd1 << lv[i]);
      run_check("R2 policy", 3'(lv[i]), 3'd7, 32'd9, 40'h0, 1'b0, 2'd1);
    end
    strict_rev = 1'b1;
    policy_mask = 8'hEF;
    run_check("R2 policy before R3", 3'd4, 3'd7, 32'd9, 40'h0, 1'b0, 2'd1);
    strict_rev = 1'b0;
    policy_mask = 8'hFF;
  endtask

  task automatic t_enconly;
    strict_rev = 1'b1;
    run_check("R3 barred", 3'd4, 3'd7, 32'd3, 40'h0, 1'b0, 2'd2);
    run_check("R3 tagged ok", 3'd5, 3'd7, 32'd3, 40'h0, 1'b0, 2'd0);
    strict_rev = 1'b0;
    run_check("R3 allowed", 3'd4, 3'd7, 32'd3, 40'h0, 1'b0, 2'd0);
  endtask

  task automatic t_replay;
    commit(3'd2, 32'd100, 1'b0);
    run_check("R4 equal", 3'd5, 3'd2, 32'd100, 40'h0, 1'b0, 2'd3);
    run_check("R4 lower", 3'd5, 3'd2, 32'd99, 40'h0, 1'b0, 2'd3);
    run_check("R4 higher", 3'd5, 3'd2, 32'd101, 40'h0, 1'b0, 2'd0);
    strict_rev = 1'b1;
    run_check("R3 before R4", 3'd4, 3'd2, 32'd50, 40'h0, 1'b0, 2'd2);
    strict_rev = 1'b0;
  endtask

  task automatic t_fresh;
    run_check("R5 fresh zero", 3'd1, 3'd3, 32'd0, 40'h0, 1'b0, 2'd0);
  endtask

  task automatic t_no_update;
    run_check("R6 first", 3'd6, 3'd3, 32'd10, 40'h0, 1'b0, 2'd0);
    run_check("R6 repeat no commit", 3'd6, 3'd3, 32'd10, 40'h0, 1'b0, 2'd0);
    commit(3'd3, 32'd10, 1'b0);
    run_check("R6 after commit", 3'd6, 3'd3, 32'd10, 40'h0, 1'b0, 2'd3);
    run_check("R6 next", 3'd6, 3'd3, 32'd11, 40'h0, 1'b0, 2'd0);
  endtask

  task automatic t_tsch;
    run_check("R7 slot counter", 3'd7, 3'd2, 32'd5, 40'h12_3456_789A, 1'b1, 2'd0);
    run_check("R7 legacy counter", 3'd7, 3'd2, 32'hDEAD_BEEF, 40'hFF_0000_0000, 1'b0, 2'd0);
  endtask

  task automatic t_level0;
    run_check("R8 unsecured", 3'd0, 3'd2, 32'd1, 40'h0, 1'b0, 2'd0);
  endtask

  task automatic t_commit_tsch;
    commit(3'd4, 32'd500, 1'b1);
    run_check("R10 slotted commit ignored", 3'd1, 3'd4, 32'd1, 40'h0, 1'b0, 2'd0);
  endtask

  task automatic t_same_cycle;
    logic [1:0] r;
    commit(3'd5, 32'd20, 1'b0);
    @(negedge clk);
    commit_req = 1'b1; commit_nbr = 3'd5; commit_ctr = 32'd30;
    chk_req = 1'b1; chk_level = 3'd2; chk_nbr = 3'd5; chk_hdr_ctr = 32'd25;
    @(negedge clk);
    commit_req = 1'b0; chk_req = 1'b0;
    r = res_reason;
    check_line("R11 old value used", res_valid && res_accept && r == 2'd0,
               $sformatf("v=%0b a=%0b r=%0d", res_valid, res_accept, r), "v=1 a=1 r=0");
    run_check("R11 new value after", 3'd2, 3'd5, 32'd25, 40'h0, 1'b0, 2'd3);
  endtask

  task automatic t_timing;
    run_check("R9 pulse", 3'd3, 3'd7, 32'd77, 40'h0, 1'b0, 2'd0);
    @(negedge clk);
    check_line("R9 single cycle", !res_valid, $sformatf("v=%0b", res_valid), "v=0");
  endtask

  initial begin
    total = 0; bad = 0; done = 0;
    rst_n = 1'b0; mode_tsch = 1'b0; strict_rev = 1'b0; policy_mask = 8'hFF;
    chk_req = 1'b0; chk_level = '0; chk_nbr = '0; chk_hdr_ctr = '0; chk_asn = '0;
    commit_req = 1'b0; commit_nbr = '0; commit_ctr = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_policy();
    t_enconly();
    t_replay();
    t_fresh();
    t_no_update();
    t_tsch();
    t_level0();
    t_commit_tsch();
    t_same_cycle();
    t_timing();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule